// File: doc/BRIEF.md
# SD Card Block Transfer Sequencer

This block turns a block-level read or write request into the ordered sequence of operations that a card host controller needs. The card must already be initialised. A request names a starting block, a number of blocks and a direction. The sequencer programs the block size and block count, issues the data command with an address in the unit the card expects, starts the data engine, and then closes the transfer. Command words go to a command engine and come back with a completion. The payload moves through a separate data engine, which reports the end of each data phase.

Two operating styles are selected per request:

- **Multi-block.** One data command covers the whole request. A stop command always follows it, whether the attempt succeeded or failed. A failed attempt is restarted from the beginning, and the third consecutive failure ends the request with an error.
- **Single-block.** Each block gets its own setup, command and data phase, with the address advancing one block at a time. Any error ends the request at once.

High-capacity cards take block addresses, and all other cards take byte addresses. On success the block reports the number of bytes moved.

The controller is a single state machine with these states:

| State | What happens |
|---|---|
| IDLE | Waits for a request. |
| SETUP | Pulses the size and count setup. |
| DCMD | Holds the data command. |
| DSTART | Pulses the data engine start. |
| DWAIT | Waits for the data phase to end. |
| STOP | Holds the stop command. |
| ASSESS | Decides between retry, failure and success. |
| NEXT | Advances to the next block in single-block mode. |
| DONE | Pulses success. |
| FAIL | Pulses failure. |

Its transitions are:

- IDLE→FAIL when the card is offline.
- IDLE→DONE when the count is zero.
- IDLE→SETUP otherwise.
- SETUP→DCMD.
- DCMD→DSTART when the command succeeds.
- DCMD→STOP when the command fails in multi-block mode.
- DCMD→FAIL when the command fails in single-block mode.
- DSTART→DWAIT.
- DWAIT→STOP in multi-block mode.
- DWAIT→NEXT in single-block mode when the data phase succeeds.
- DWAIT→FAIL in single-block mode when the data phase fails.
- STOP→ASSESS.
- ASSESS→DONE when the attempt was clean.
- ASSESS→SETUP to retry.
- ASSESS→FAIL when the attempts are exhausted.
- NEXT→SETUP while blocks remain.
- NEXT→DONE after the last block.
- DONE→IDLE and FAIL→IDLE.

Top module: `sd_block_seq`

## Requirements
- R1: A request made while `card_online` is low ends with `fail` and `fail_media` high for one cycle, with no setup, command or data activity.
- R2: Every data command is preceded by a `setup_valid` pulse. That pulse carries `setup_blk_size` = 2^BLK_LOG2 (512 by default) and a block count equal to the request count in multi-block mode, or 1 in single-block mode.
- R3: The data command index is 18 for a multi-block read, 25 for a multi-block write, 17 for a single-block read and 24 for a single-block write. `data_write` follows the direction (1 = write).
- R4: The data command argument is the block number when bit 30 of `card_ocr` was set at request time. Otherwise it is the block number shifted left by BLK_LOG2, truncated to 32 bits.
- R5: In multi-block mode, a stop command (index 12, argument 0) follows every data command. This holds when the data phase succeeds, when it fails, and when the data command itself fails; in the last case no data phase is started.
- R6: A multi-block attempt fails if its data command, its data phase or its stop command reports an error. A failed attempt is restarted from the setup step. The third consecutive failed attempt ends the request with `fail` high and `fail_media` low.
- R7: In single-block mode, block i of the request is handled by its own setup, command and data phase, with the address computed for start+i. The first error ends the request with `fail`, with no stop command and no retry.
- R8: A successful request ends with `done` high for one cycle and `xfer_bytes` equal to count × 2^BLK_LOG2. `xfer_bytes` is 0 whenever `done` is low, and `done` and `fail` are never high together.
- R9: A request with a count of zero, on an online card, ends with `done` and `xfer_bytes` = 0, with no setup, command or data activity.
- R10: Once raised, `cmd_valid` stays high with unchanged index and argument until the cycle in which `cmd_done` is high.
- R11: A `req_start` pulse while `busy` is high is ignored: the running sequence continues unchanged and no new request starts afterwards.
- R12: After reset, `busy`, `setup_valid`, `cmd_valid`, `data_start`, `done` and `fail` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle request pulse, accepted when idle |
| req_write | input | 1 | 1 = write to card, 0 = read |
| req_multi | input | 1 | 1 = multi-block mode, 0 = single-block mode |
| req_block | input | 32 | First block number |
| req_count | input | CNT_W | Number of blocks |
| card_online | input | 1 | Card has been initialised |
| card_ocr | input | 32 | Operating conditions word; bit 30 marks high capacity |
| busy | output | 1 | A request is in progress |
| setup_valid | output | 1 | One-cycle pulse programming size and count |
| setup_blk_size | output | 16 | Block size in bytes |
| setup_blk_count | output | CNT_W | Blocks in the coming data phase |
| cmd_valid | output | 1 | Command request, held until completion |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command engine completion |
| cmd_err | input | 1 | Error, qualified by `cmd_done` |
| data_start | output | 1 | One-cycle pulse starting the data engine |
| data_write | output | 1 | Direction for the data engine |
| data_done | input | 1 | Data phase finished |
| data_err | input | 1 | Data phase error, qualified by `data_done` |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| fail_media | output | 1 | With `fail`: card was not initialised |
| xfer_bytes | output | CNT_W+BLK_LOG2 | Bytes transferred, valid with `done` |

## Verification
The bench plays both engines, injecting failures into data commands, data phases and stop commands. It compares the full ordered log of setups, commands and data starts against a model built from the requirements.

The corner cases it targets, and how a faulty design would show up:

- **Failed data command in multi-block mode.** A design that skipped the stop here would show a log missing index 12.
- **Stop-command failures.** A design that ignored them would finish instead of retrying.
- **Three consecutive failures.** A design with an off-by-one retry limit would make a fourth attempt or give up after two.
- **Byte addressing near the 32-bit limit.** A design with a wrong shift or no truncation would show the wrong argument.
- **Zero-count and offline requests.** A design that issued commands for these would show a non-empty log.
- **Single-block advance and early stop.** A design that failed to advance the block or retried in single-block mode would give a different log length and different addresses.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DCMD,
        ST_DSTART,
        ST_DWAIT,
        ST_STOP,
        ST_ASSESS,
        ST_NEXT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam logic [5:0] IDX_STOP      = 6'd12;
    localparam logic [5:0] IDX_RD_SINGLE = 6'd17;
    localparam logic [5:0] IDX_RD_MULTI  = 6'd18;
    localparam logic [5:0] IDX_WR_SINGLE = 6'd24;
    localparam logic [5:0] IDX_WR_MULTI  = 6'd25;

    localparam int HC_BIT = 30;

endpackage

// File: rtl/sd_seq_cmdsel.sv
module sd_seq_cmdsel
    import sd_seq_pkg::*;
(
    input  logic       is_stop,
    input  logic       multi,
    input  logic       write,
    output logic [5:0] index
);

    always_comb begin
        if (is_stop) begin
            index = IDX_STOP;
        end else begin
            unique case ({multi, write})
                2'b00:   index = IDX_RD_SINGLE;
                2'b01:   index = IDX_WR_SINGLE;
                2'b10:   index = IDX_RD_MULTI;
                default: index = IDX_WR_MULTI;
            endcase
        end
    end

endmodule

// File: rtl/sd_seq_addr.sv
module sd_seq_addr #(
    parameter int BLK_LOG2 = 9
) (
    input  logic [31:0] blk,
    input  logic        high_cap,
    output logic [31:0] arg
);

    generate
        if (BLK_LOG2 == 0) begin : g_unit
            assign arg = blk;
        end else begin : g_shift
            logic [31:0] byte_addr;
            assign byte_addr = {blk[31-BLK_LOG2:0], {BLK_LOG2{1'b0}}};
            assign arg       = high_cap ? blk : byte_addr;
        end
    endgenerate

endmodule

// File: rtl/sd_seq_retry.sv
module sd_seq_retry #(
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);

    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [TW-1:0] fails_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fails_q <= '0;
        end else if (clear) begin
            fails_q <= '0;
        end else if (bump) begin
            fails_q <= fails_q + 1'b1;
        end
    end

    assign last_try = (fails_q == TW'(MAX_TRIES - 1));

    // R6: the failure tally never reaches the attempt limit
    a_r6_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fails_q < TW'(MAX_TRIES));

    // R6: a bump never happens on the final permitted attempt
    a_r6_no_bump_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        last_try |-> !bump);

endmodule

// File: rtl/sd_block_seq.sv
module sd_block_seq
    import sd_seq_pkg::*;
#(
    parameter int BLK_LOG2  = 9,
    parameter int CNT_W     = 16,
    parameter int MAX_TRIES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_start,
    input  logic                      req_write,
    input  logic                      req_multi,
    input  logic [31:0]               req_block,
    input  logic [CNT_W-1:0]          req_count,
    input  logic                      card_online,
    input  logic [31:0]               card_ocr,
    output logic                      busy,
    output logic                      setup_valid,
    output logic [15:0]               setup_blk_size,
    output logic [CNT_W-1:0]          setup_blk_count,
    output logic                      cmd_valid,
    output logic [5:0]                cmd_index,
    output logic [31:0]               cmd_arg,
    input  logic                      cmd_done,
    input  logic                      cmd_err,
    output logic                      data_start,
    output logic                      data_write,
    input  logic                      data_done,
    input  logic                      data_err,
    output logic                      done,
    output logic                      fail,
    output logic                      fail_media,
    output logic [CNT_W+BLK_LOG2-1:0] xfer_bytes
);

    localparam int BYTES_W   = CNT_W + BLK_LOG2;
    localparam int BLK_BYTES = 1 << BLK_LOG2;

    seq_state_t st, st_n;

    logic               wr_q;
    logic               multi_q;
    logic               hc_q;
    logic               media_q;
    logic               att_bad;
    logic [31:0]        cur_blk;
    logic [CNT_W-1:0]   total_q;
    logic [CNT_W-1:0]   remain_q;
    logic [BYTES_W-1:0] bytes_q;

    logic               accept;
    logic               last_try;
    logic               retry_bump;
    logic               is_stop;
    logic [5:0]         sel_index;
    logic [31:0]        addr_arg;

    assign accept     = (st == ST_IDLE) && req_start;
    assign is_stop    = (st == ST_STOP);
    assign retry_bump = (st == ST_ASSESS) && att_bad && !last_try;

    sd_seq_cmdsel u_cmdsel (
        .is_stop (is_stop),
        .multi   (multi_q),
        .write   (wr_q),
        .index   (sel_index)
    );

    sd_seq_addr #(.BLK_LOG2(BLK_LOG2)) u_addr (
        .blk      (cur_blk),
        .high_cap (hc_q),
        .arg      (addr_arg)
    );

    sd_seq_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bump     (retry_bump),
        .last_try (last_try)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (req_start) begin
                    if (!card_online) begin
                        st_n = ST_FAIL;
                    end else if (req_count == '0) begin
                        st_n = ST_DONE;
                    end else begin
                        st_n = ST_SETUP;
                    end
                end
            end
            ST_SETUP:  st_n = ST_DCMD;
            ST_DCMD: begin
                if (cmd_done) begin
                    if (cmd_err) begin
                        st_n = multi_q ? ST_STOP : ST_FAIL;
                    end else begin
                        st_n = ST_DSTART;
                    end
                end
            end
            ST_DSTART: st_n = ST_DWAIT;
            ST_DWAIT: begin
                if (data_done) begin
                    if (multi_q) begin
                        st_n = ST_STOP;
                    end else if (data_err) begin
                        st_n = ST_FAIL;
                    end else begin
                        st_n = ST_NEXT;
                    end
                end
            end
            ST_STOP: begin
                if (cmd_done) begin
                    st_n = ST_ASSESS;
                end
            end
            ST_ASSESS: begin
                if (!att_bad) begin
                    st_n = ST_DONE;
                end else if (last_try) begin
                    st_n = ST_FAIL;
                end else begin
                    st_n = ST_SETUP;
                end
            end
            ST_NEXT:   st_n = (remain_q == CNT_W'(1)) ? ST_DONE : ST_SETUP;
            ST_DONE:   st_n = ST_IDLE;
            ST_FAIL:   st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // Request context and attempt bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            multi_q  <= 1'b0;
            hc_q     <= 1'b0;
            media_q  <= 1'b0;
            att_bad  <= 1'b0;
            cur_blk  <= '0;
            total_q  <= '0;
            remain_q <= '0;
            bytes_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_start) begin
                        wr_q     <= req_write;
                        multi_q  <= req_multi;
                        hc_q     <= card_ocr[HC_BIT];
                        media_q  <= !card_online;
                        att_bad  <= 1'b0;
                        cur_blk  <= req_block;
                        total_q  <= req_count;
                        remain_q <= req_count;
                        bytes_q  <= BYTES_W'(req_count) << BLK_LOG2;
                    end
                end
                ST_SETUP: att_bad <= 1'b0;
                ST_DCMD: begin
                    if (cmd_done && cmd_err) begin
                        att_bad <= 1'b1;
                    end
                end
                ST_DWAIT: begin
                    if (data_done && data_err) begin
                        att_bad <= 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cmd_done && cmd_err) begin
                        att_bad <= 1'b1;
                    end
                end
                ST_NEXT: begin
                    remain_q <= remain_q - 1'b1;
                    cur_blk  <= cur_blk + 32'd1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy            = (st != ST_IDLE);
        setup_valid     = (st == ST_SETUP);
        setup_blk_size  = 16'(BLK_BYTES);
        setup_blk_count = multi_q ? total_q : CNT_W'(1);
        cmd_valid       = (st == ST_DCMD) || (st == ST_STOP);
        cmd_index       = sel_index;
        cmd_arg         = is_stop ? 32'd0 : addr_arg;
        data_start      = (st == ST_DSTART);
        data_write      = wr_q;
        done            = (st == ST_DONE);
        fail            = (st == ST_FAIL);
        fail_media      = (st == ST_FAIL) && media_q;
        xfer_bytes      = (st == ST_DONE) ? bytes_q : '0;
    end

    // Observation state for the assertions below
    logic setup_seen;
    logic data_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_seen <= 1'b0;
            data_open  <= 1'b0;
        end else begin
            if (setup_valid) begin
                setup_seen <= 1'b1;
            end else if (cmd_valid && cmd_done && cmd_index != IDX_STOP) begin
                setup_seen <= 1'b0;
            end
            if (data_start && multi_q) begin
                data_open <= 1'b1;
            end else if (cmd_valid && cmd_done && cmd_index == IDX_STOP) begin
                data_open <= 1'b0;
            end
        end
    end

    // R10: a pending command holds its index and argument
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

    // R1: an offline card causes an immediate media failure
    a_r1_media_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy && !card_online) |=> (fail && fail_media));

    // R8: success and failure never coincide
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R2: a data command is only raised after a setup pulse
    a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_index != IDX_STOP) |-> setup_seen);

    // R5: a multi-block data phase is always closed by a stop before completion
    a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !data_open);

    // R11: a busy block does not fall back to idle because of a new request
    a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_start && !done && !fail) |=> busy);

endmodule

// File: tb/sd_block_seq_tb_top.sv
module sd_block_seq_tb_top;

    localparam int BLK_LOG2 = 9;
    localparam int CNT_W    = 16;
    localparam int BW       = CNT_W + BLK_LOG2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_start = 1'b0;
    logic             req_write = 1'b0;
    logic             req_multi = 1'b0;
    logic [31:0]      req_block = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             card_online = 1'b0;
    logic [31:0]      card_ocr = '0;
    logic             busy;
    logic             setup_valid;
    logic [15:0]      setup_blk_size;
    logic [CNT_W-1:0] setup_blk_count;
    logic             cmd_valid;
    logic [5:0]       cmd_index;
    logic [31:0]      cmd_arg;
    logic             cmd_done = 1'b0;
    logic             cmd_err = 1'b0;
    logic             data_start;
    logic             data_write;
    logic             data_done = 1'b0;
    logic             data_err = 1'b0;
    logic             done;
    logic             fail;
    logic             fail_media;
    logic [BW-1:0]    xfer_bytes;

    always #4 clk = ~clk;

    sd_block_seq #(.BLK_LOG2(BLK_LOG2), .CNT_W(CNT_W), .MAX_TRIES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_multi(req_multi), .req_block(req_block), .req_count(req_count),
        .card_online(card_online), .card_ocr(card_ocr), .busy(busy),
        .setup_valid(setup_valid), .setup_blk_size(setup_blk_size),
        .setup_blk_count(setup_blk_count), .cmd_valid(cmd_valid),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .data_start(data_start), .data_write(data_write),
        .data_done(data_done), .data_err(data_err), .done(done), .fail(fail),
        .fail_media(fail_media), .xfer_bytes(xfer_bytes)
    );

    int checks = 0;
    int errors = 0;

    // Event log entries: {kind[1:0], index[5:0], arg[31:0]}
    // kind 1 = setup (arg = count), 2 = command, 3 = data start (arg = direction)
    logic [39:0] act_log [64];
    logic [39:0] exp_log [64];
    int act_n = 0;
    int exp_n = 0;
    int size_bad = 0;
    int inj_dcmd = 0;
    int inj_data = 0;
    int inj_stop = 0;
    int dwait = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Card-side responder for the command and data engines
    always @(negedge clk) begin
        if (rst_n) begin
            if (setup_valid) begin
                if (act_n < 64) act_log[act_n] = {2'd1, 6'd0, 32'(setup_blk_count)};
                act_n++;
                if (setup_blk_size != 16'd512) size_bad++;
            end
            if (cmd_done) begin
                cmd_done = 1'b0;
                cmd_err  = 1'b0;
            end else if (cmd_valid) begin
                if (act_n < 64) act_log[act_n] = {2'd2, cmd_index, cmd_arg};
                act_n++;
                cmd_done = 1'b1;
                if (cmd_index == 6'd12) begin
                    if (inj_stop > 0) begin cmd_err = 1'b1; inj_stop--; end
                end else if (inj_dcmd > 0) begin
                    cmd_err = 1'b1; inj_dcmd--;
                end
            end
            if (data_done) begin
                data_done = 1'b0;
                data_err  = 1'b0;
            end else if (dwait > 0) begin
                dwait--;
                if (dwait == 0) begin
                    data_done = 1'b1;
                    if (inj_data > 0) begin data_err = 1'b1; inj_data--; end
                end
            end
            if (data_start) begin
                if (act_n < 64) act_log[act_n] = {2'd3, 6'd0, 31'd0, data_write};
                act_n++;
                dwait = 3;
            end
        end
    end

    function automatic logic [31:0] addr_of(input bit hc, input logic [31:0] b);
        return hc ? b : (b << BLK_LOG2);
    endfunction

    task automatic push(input logic [39:0] e);
        if (exp_n < 64) exp_log[exp_n] = e;
        exp_n++;
    endtask

    // Expected behaviour built from the requirements
    task automatic model(input bit wr, input bit multi, input logic [31:0] blk,
                         input int cnt, input bit online, input bit hc,
                         input int d0, input int c0, input int s0,
                         output bit e_done, output bit e_media, output logic [63:0] e_bytes);
        int d = d0;
        int c = c0;
        int s = s0;
        logic [5:0] idx;
        exp_n = 0;
        e_done = 1'b0;
        e_media = 1'b0;
        e_bytes = 64'd0;
        if (!online) begin e_media = 1'b1; return; end
        if (cnt == 0) begin e_done = 1'b1; return; end
        if (multi) begin
            idx = wr ? 6'd25 : 6'd18;
            for (int t = 0; t < 3; t++) begin
                bit bad = 1'b0;
                push({2'd1, 6'd0, 32'(cnt)});
                push({2'd2, idx, addr_of(hc, blk)});
                if (c > 0) begin
                    c--; bad = 1'b1;
                end else begin
                    push({2'd3, 6'd0, 31'd0, wr});
                    if (d > 0) begin d--; bad = 1'b1; end
                end
                push({2'd2, 6'd12, 32'd0});
                if (s > 0) begin s--; bad = 1'b1; end
                if (!bad) begin
                    e_done = 1'b1;
                    e_bytes = 64'(cnt) << BLK_LOG2;
                    return;
                end
            end
        end else begin
            idx = wr ? 6'd24 : 6'd17;
            for (int i = 0; i < cnt; i++) begin
                push({2'd1, 6'd0, 32'd1});
                push({2'd2, idx, addr_of(hc, blk + 32'(i))});
                if (c > 0) return;
                push({2'd3, 6'd0, 31'd0, wr});
                if (d > 0) return;
            end
            e_done = 1'b1;
            e_bytes = 64'(cnt) << BLK_LOG2;
        end
    endtask

    task automatic run(input bit wr, input bit multi, input logic [31:0] blk,
                       input int cnt, input bit online, input bit hc,
                       input int d0, input int c0, input int s0,
                       input bit spurious, input string tag);
        bit e_done, e_media, g_done, g_fail, g_media, seq_ok;
        logic [63:0] e_bytes, g_bytes;
        int cyc = 0;
        int n_after;
        model(wr, multi, blk, cnt, online, hc, d0, c0, s0, e_done, e_media, e_bytes);
        inj_data = d0; inj_dcmd = c0; inj_stop = s0;
        act_n = 0; size_bad = 0;
        @(negedge clk);
        req_write = wr; req_multi = multi; req_block = blk;
        req_count = CNT_W'(cnt); card_online = online;
        card_ocr = hc ? 32'h4000_0000 : 32'h8030_0000;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (!(done || fail) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (spurious && cyc == 3) begin
                req_start = 1'b1; req_block = 32'h1234; req_count = 16'd7;
                req_multi = ~multi; req_write = ~wr;
            end else begin
                req_start = 1'b0;
            end
        end
        req_start = 1'b0;
        g_done = done; g_fail = fail; g_media = fail_media; g_bytes = 64'(xfer_bytes);
        chk(cyc < 2000, tag, "completion seen", 64'(cyc), 64'd2000);
        chk(g_done == e_done && g_fail == !e_done, tag, "outcome done/fail",
            {g_done, g_fail}, {e_done, !e_done});
        chk(g_media == e_media, tag, "media flag", 64'(g_media), 64'(e_media));
        chk(g_bytes == e_bytes, tag, "byte count", g_bytes, e_bytes);
        n_after = act_n;
        repeat (4) @(negedge clk);
        chk(!busy && act_n == n_after, tag, "idle after completion",
            {busy, 32'(act_n)}, {1'b0, 32'(n_after)});
        seq_ok = (act_n == exp_n) && (act_n <= 64);
        for (int i = 0; i < exp_n && i < 64; i++) begin
            if (seq_ok && act_log[i] !== exp_log[i]) begin
                seq_ok = 1'b0;
                $display("  entry %0d differs: actual=%0h expected=%0h", i, act_log[i], exp_log[i]);
            end
        end
        chk(seq_ok, tag, "operation sequence length", 64'(act_n), 64'(exp_n));
        chk(size_bad == 0, tag, "setup block size (R2)", 64'(size_bad), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20121019));
        repeat (5) @(negedge clk);
        // R12: reset state
        chk(!busy && !setup_valid && !cmd_valid && !data_start && !done && !fail,
            "R12", "outputs during reset",
            {busy, setup_valid, cmd_valid, data_start, done, fail}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !cmd_valid && !done && !fail, "R12", "outputs after reset",
            {busy, cmd_valid, done, fail}, 64'd0);

        // R1: card not initialised
        run(1'b0, 1'b1, 32'd10, 4, 1'b0, 1'b1, 0, 0, 0, 1'b0, "R1");
        // R3 R4: multi read, block addressing
        run(1'b0, 1'b1, 32'd100, 5, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R3_R4");
        // R3 R4 R8: multi write, byte addressing
        run(1'b1, 1'b1, 32'd7, 3, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R3_R4_R8");
        // R4: byte address truncated to 32 bits
        run(1'b0, 1'b1, 32'h0090_0001, 2, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R4");
        // R5 R6: data phase fails once, stop still sent, retry succeeds
        run(1'b0, 1'b1, 32'd55, 2, 1'b1, 1'b1, 1, 0, 0, 1'b0, "R5_R6");
        // R5: data command fails, stop sent with no data phase
        run(1'b1, 1'b1, 32'd9, 2, 1'b1, 1'b0, 0, 1, 0, 1'b0, "R5");
        // R6: three consecutive failures
        run(1'b1, 1'b1, 32'd9, 2, 1'b1, 1'b1, 3, 0, 0, 1'b0, "R6");
        // R6: stop failures count, third attempt succeeds
        run(1'b0, 1'b1, 32'd3, 1, 1'b1, 1'b1, 0, 0, 2, 1'b0, "R6");
        // R7: single-block read, four blocks
        run(1'b0, 1'b0, 32'd20, 4, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");
        // R7: single-block write, error on first block ends at once
        run(1'b1, 1'b0, 32'd20, 4, 1'b1, 1'b1, 1, 0, 0, 1'b0, "R7");
        // R7: single-block command error, no retry, no stop
        run(1'b0, 1'b0, 32'd40, 3, 1'b1, 1'b1, 0, 1, 0, 1'b0, "R7");
        // R9: zero count
        run(1'b0, 1'b1, 32'd5, 0, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R9");
        // R11: request while busy is ignored
        run(1'b1, 1'b1, 32'd77, 3, 1'b1, 1'b1, 0, 0, 0, 1'b1, "R11");
        run(1'b0, 1'b0, 32'd77, 3, 1'b1, 1'b0, 0, 0, 0, 1'b1, "R11");

        // Constrained random mix (R2 R3 R4 R5 R6 R7 R8 R10)
        for (int k = 0; k < 40; k++) begin
            bit wr = 1'($urandom % 2);
            bit mu = 1'($urandom % 2);
            bit hc = 1'($urandom % 2);
            bit on = ($urandom % 8) != 0;
            int cn = int'($urandom % 6);
            logic [31:0] bk = $urandom;
            int dd = (($urandom % 3) == 0) ? int'($urandom % 4) : 0;
            int cc = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
            int ss = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
            run(wr, mu, bk, cn, on, hc, dd, cc, ss, 1'b0, "R2_R3_R4_R5_R6_R7_R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule